// File: doc/BRIEF.md
# Segmented Address Extender for an 8-bit Core

This block sits between an unmodified 8-bit core with a 16-bit address bus and a memory system that takes 32-bit byte addresses on a 32-bit data path. Each core bus cycle is sorted into one of six kinds: a reset or IRQ vector read, an NMI vector read, an instruction-stream read, a stack-page access, a zero-page access, or a plain data access. The block then places a 16-bit segment above the 16-bit offset to form the physical address. It also drives a one-hot byte-lane enable for the 32-bit data path.

Software loads the segment values by writing bytes into a small register window. The code segment never changes on an ordinary fetch. A staged value is copied into it when a jump, a subroutine call, a software break or an NMI takes place, and the code segment that was left is saved on an internal shadow stack. Return instructions take the saved value back off that stack. Zero-page accesses are moved to a direct page chosen for the running code segment. A move mode sends reads and writes to two different data segments, so block copies can run between segments.

Top module: `seg_ext_top`

## Requirements
- R1: `phys_addr` is {segment, offset}, where the offset is `cpu_addr` unchanged for every cycle that is not a zero-page data cycle. After reset every segment register, every direct-page entry and move mode are 0, so the physical address equals `cpu_addr` zero-extended.
- R2: `byte_en` has exactly one bit set, bit `phys_addr[1:0]` (little-endian byte lanes on a 32-bit path).
- R3: Priority from highest to lowest is: vector read (`cpu_vec`), instruction-stream read (`cpu_sync` or `cpu_prog`, which uses the code segment), stack page `$01xx` (stack segment), zero page `$00xx`, other data. Move mode has no effect on stack cycles.
- R4: A zero-page data cycle uses offset {direct page, `cpu_addr[7:0]`}. The direct page comes from one of 4 entries, chosen by bits [1:0] of the code segment in effect, and the cycle uses the data segment of its direction.
- R5: The register window is logical `$FF00`..`$FF09`. It responds to byte writes whose data segment is 0. The offsets are: 0/1 staged code segment, 2/3 data segment 0, 4/5 data segment 1, 6/7 stack segment, 8 the direct page of the running code segment, 9 bit 0 move mode. A 16-bit register changes only when its odd (high) byte is written, taking the low byte held from the last even-offset write. A window write whose data segment is not 0 changes nothing.
- R6: With move mode clear, data reads and writes use data segment 0. With move mode set, reads use data segment 0 and writes use data segment 1.
- R7: The first opcode fetch after an opcode fetch of `$4C`, `$6C`, `$20` or `$00` already uses the staged code segment, and that segment becomes active. No other fetch changes the code segment.
- R8: An NMI vector read at `$FFFA` uses the staged code segment and makes it active, saving the old one. The read at `$FFFB` uses the active segment.
- R9: Reads with `cpu_vec` at `$FFFC`..`$FFFF` use segment 0. An IRQ vector read at `$FFFE` that does not follow a `$00` opcode saves the active code segment without changing it.
- R10: A `$20` or `$00` opcode saves the old code segment when the switch happens. After a `$60` or `$40` opcode, the next opcode fetch restores the most recently saved segment. The stack holds 8 entries, and a save into a full stack drops the oldest entry.
- R11: A restore when the stack is empty leaves the code segment unchanged and sets `cs_fault`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Core logical address |
| cpu_wdata | input | 8 | Core write data (register window) |
| cpu_rdata | input | 8 | Byte read by the core (opcode snoop) |
| cpu_we | input | 1 | Core write strobe |
| cpu_sync | input | 1 | Opcode fetch cycle |
| cpu_prog | input | 1 | Instruction-stream (operand) read |
| cpu_vec | input | 1 | Interrupt vector read |
| phys_addr | output | 32 | Physical byte address |
| byte_en | output | 4 | Byte-lane enables |
| cs_fault | output | 1 | Sticky shadow-stack underflow |

## Verification
Two cases need care because two functions act in the same cycle. The first is a zero-page write made while move mode is set: the direct-page replacement and the write-side segment choice both shape that one address. The bench builds this case by loading a direct page and a second data segment and then setting move mode. It then expects a zero-page write to carry data segment 1 and the relocated page, while a zero-page read in the next cycle keeps data segment 0. The second case is the opcode fetch that ends a jump or return. In that cycle the switch or restore must already appear on the fetch address, and the opcode just fetched must be armed for the following fetch. This is judged by checking each fetch address after sequences of jumps, calls, a nine-deep call chain and its returns.

// File: rtl/seg_ext_pkg.sv
package seg_ext_pkg;

   typedef enum logic [2:0] {
      CLS_VEC_BOOT,
      CLS_VEC_NMI,
      CLS_CODE,
      CLS_STACK,
      CLS_ZP,
      CLS_DATA
   } cyc_class_e;

   // opcodes that steer the code segment
   localparam logic [7:0] OPC_JMP_ABS = 8'h4C;
   localparam logic [7:0] OPC_JMP_IND = 8'h6C;
   localparam logic [7:0] OPC_JSR     = 8'h20;
   localparam logic [7:0] OPC_BRK     = 8'h00;
   localparam logic [7:0] OPC_RTS     = 8'h60;
   localparam logic [7:0] OPC_RTI     = 8'h40;

   // vector addresses
   localparam logic [15:0] VEC_NMI_ADDR = 16'hFFFA;
   localparam logic [15:0] VEC_IRQ_ADDR = 16'hFFFE;

   // register window byte offsets
   localparam logic [3:0] WOFF_PCS_HI = 4'd1;
   localparam logic [3:0] WOFF_DS0_HI = 4'd3;
   localparam logic [3:0] WOFF_DS1_HI = 4'd5;
   localparam logic [3:0] WOFF_SS_HI  = 4'd7;
   localparam logic [3:0] WOFF_DPAGE  = 4'd8;
   localparam logic [3:0] WOFF_CTRL   = 4'd9;

endpackage

// File: rtl/seg_ext_regs.sv
module seg_ext_regs
   import seg_ext_pkg::*;
#(
   parameter int          SEG_W      = 16,
   parameter logic [15:0] WIN_BASE   = 16'hFF00,
   parameter int          DP_ENTRIES = 4,
   parameter int          DP_IDX_W   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [15:0]         addr,
   input  logic [7:0]          wdata,
   input  logic [DP_IDX_W-1:0] dp_idx,
   output logic [SEG_W-1:0]    pend_cs,
   output logic [SEG_W-1:0]    ds0,
   output logic [SEG_W-1:0]    ds1,
   output logic [SEG_W-1:0]    ss,
   output logic [7:0]          dp_page,
   output logic                move_en
);

   logic        in_win;
   logic [3:0]  off;
   logic        hit;
   logic [7:0]  lo_hold;
   logic [15:0] joined;
   logic [SEG_W-1:0] wide;
   logic [7:0]  dp_q [DP_ENTRIES];

   assign off    = addr[3:0];
   assign in_win = (addr[15:4] == WIN_BASE[15:4]) && (off <= WOFF_CTRL);
   assign hit    = wr_en && in_win;
   assign joined = {wdata, lo_hold};
   assign wide   = joined[SEG_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_hold <= '0;
         pend_cs <= '0;
         ds0     <= '0;
         ds1     <= '0;
         ss      <= '0;
         move_en <= 1'b0;
      end else if (hit) begin
         if (!off[0] && off < WOFF_DPAGE) lo_hold <= wdata;
         case (off)
            WOFF_PCS_HI: pend_cs <= wide;
            WOFF_DS0_HI: ds0     <= wide;
            WOFF_DS1_HI: ds1     <= wide;
            WOFF_SS_HI:  ss      <= wide;
            WOFF_CTRL:   move_en <= wdata[0];
            default: ;
         endcase
      end
   end

   for (genvar i = 0; i < DP_ENTRIES; i++) begin : g_dp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            dp_q[i] <= '0;
         else if (hit && off == WOFF_DPAGE && dp_idx == DP_IDX_W'(i))
            dp_q[i] <= wdata;
      end
   end

   assign dp_page = dp_q[dp_idx];

endmodule

// File: rtl/seg_ext_cs_ctrl.sv
module seg_ext_cs_ctrl
   import seg_ext_pkg::*;
#(
   parameter int SEG_W = 16,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync,
   input  logic             vec,
   input  logic [15:0]      addr,
   input  logic [7:0]       rdata,
   input  logic [SEG_W-1:0] pend_cs,
   output logic [SEG_W-1:0] cs_eff,
   output logic             fault
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [SEG_W-1:0] act_cs;
   logic [SEG_W-1:0] stk [DEPTH];
   logic [CNT_W-1:0] cnt;
   logic arm_sw, arm_push, arm_pop;
   logic nmi_hit, irq_hit, sw_now, pop_now, can_pop, do_push, do_pop;

   assign nmi_hit = vec && !sync && (addr == VEC_NMI_ADDR);
   assign irq_hit = vec && !sync && (addr == VEC_IRQ_ADDR) && !arm_sw;
   assign sw_now  = sync && arm_sw;
   assign pop_now = sync && !arm_sw && arm_pop;
   assign can_pop = (cnt != '0);
   assign do_push = (sw_now && arm_push) || nmi_hit || irq_hit;
   assign do_pop  = pop_now && can_pop;

   always_comb begin
      if (sw_now || nmi_hit) cs_eff = pend_cs;
      else if (do_pop)       cs_eff = stk[0];
      else                   cs_eff = act_cs;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_cs   <= '0;
         arm_sw   <= 1'b0;
         arm_push <= 1'b0;
         arm_pop  <= 1'b0;
         cnt      <= '0;
         fault    <= 1'b0;
      end else begin
         act_cs <= cs_eff;
         if (sync) begin
            arm_sw   <= (rdata == OPC_JMP_ABS) || (rdata == OPC_JMP_IND) ||
                        (rdata == OPC_JSR) || (rdata == OPC_BRK);
            arm_push <= (rdata == OPC_JSR) || (rdata == OPC_BRK);
            arm_pop  <= (rdata == OPC_RTS) || (rdata == OPC_RTI);
         end else if (nmi_hit) begin
            arm_sw   <= 1'b0;
            arm_push <= 1'b0;
         end
         if (do_push) begin
            if (cnt != CNT_W'(DEPTH)) cnt <= cnt + 1'b1;
         end else if (do_pop) begin
            cnt <= cnt - 1'b1;
         end
         if (pop_now && !can_pop) fault <= 1'b1;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_stk
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stk[i] <= '0;
         else if (do_push) begin
            if (i == 0) stk[i] <= act_cs;
            else        stk[i] <= stk[(i == 0) ? 0 : i-1];
         end else if (do_pop) begin
            if (i == DEPTH-1) stk[i] <= '0;
            else              stk[i] <= stk[(i == DEPTH-1) ? i : i+1];
         end
      end
   end

endmodule

// File: rtl/seg_ext_map.sv
module seg_ext_map
   import seg_ext_pkg::*;
#(
   parameter int SEG_W = 16,
   parameter int LANES = 4
) (
   input  logic [15:0]       addr,
   input  logic              we,
   input  logic              sync,
   input  logic              prog,
   input  logic              vec,
   input  logic [SEG_W-1:0]  cs_eff,
   input  logic [SEG_W-1:0]  ss,
   input  logic [SEG_W-1:0]  ds0,
   input  logic [SEG_W-1:0]  ds1,
   input  logic              move_en,
   input  logic [7:0]        dp_page,
   output logic [SEG_W+15:0] phys,
   output logic [LANES-1:0]  byte_en,
   output cyc_class_e        cls,
   output logic [SEG_W-1:0]  data_seg
);

   logic [SEG_W-1:0] seg;
   logic [15:0]      off;

   always_comb begin
      if (vec && addr[15:2] == 14'h3FFF)       cls = CLS_VEC_BOOT;
      else if (vec && addr[15:1] == 15'h7FFD)  cls = CLS_VEC_NMI;
      else if (sync || prog)                   cls = CLS_CODE;
      else if (addr[15:8] == 8'h01)            cls = CLS_STACK;
      else if (addr[15:8] == 8'h00)            cls = CLS_ZP;
      else                                     cls = CLS_DATA;
   end

   assign data_seg = (move_en && we) ? ds1 : ds0;

   always_comb begin
      off = addr;
      case (cls)
         CLS_VEC_BOOT: seg = '0;
         CLS_VEC_NMI,
         CLS_CODE:     seg = cs_eff;
         CLS_STACK:    seg = ss;
         CLS_ZP: begin
            seg = data_seg;
            off = {dp_page, addr[7:0]};
         end
         default:      seg = data_seg;
      endcase
   end

   assign phys = {seg, off};

   if (LANES == 1) begin : g_lane_one
      assign byte_en = 1'b1;
   end else begin : g_lane_dec
      localparam int LW = $clog2(LANES);
      assign byte_en = LANES'(1) << phys[LW-1:0];
   end

endmodule

// File: rtl/seg_ext_top.sv
module seg_ext_top
   import seg_ext_pkg::*;
#(
   parameter int          PHYS_W       = 32,
   parameter int          BUS_W        = 32,
   parameter int          SHADOW_DEPTH = 8,
   parameter int          DP_ENTRIES   = 4,
   parameter logic [15:0] WIN_BASE     = 16'hFF00
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [15:0]            cpu_addr,
   input  logic [7:0]             cpu_wdata,
   input  logic [7:0]             cpu_rdata,
   input  logic                   cpu_we,
   input  logic                   cpu_sync,
   input  logic                   cpu_prog,
   input  logic                   cpu_vec,
   output logic [PHYS_W-1:0]      phys_addr,
   output logic [BUS_W/8-1:0]     byte_en,
   output logic                   cs_fault
);

   localparam int SEG_W    = PHYS_W - 16;
   localparam int LANES    = BUS_W / 8;
   localparam int DP_IDX_W = $clog2(DP_ENTRIES);

   if (SEG_W < 9 || SEG_W > 16) begin : g_bad_phys
      $error("PHYS_W must lie between 25 and 32");
   end
   if (LANES < 1 || (LANES & (LANES - 1)) != 0 || BUS_W % 8 != 0) begin : g_bad_bus
      $error("BUS_W must be 8 times a power of two");
   end
   if (SHADOW_DEPTH < 2) begin : g_bad_depth
      $error("SHADOW_DEPTH must be at least 2");
   end
   if (DP_ENTRIES < 2 || (DP_ENTRIES & (DP_ENTRIES - 1)) != 0 || DP_ENTRIES > (1 << SEG_W)) begin : g_bad_dp
      $error("DP_ENTRIES must be a power of two of at least 2");
   end
   if (WIN_BASE[3:0] != 4'h0 || WIN_BASE[15:9] == 7'h00) begin : g_bad_win
      $error("WIN_BASE must be 16-byte aligned and above the stack page");
   end

   logic [SEG_W-1:0] pend_cs, ds0, ds1, ss, cs_eff, data_seg;
   logic [7:0]       dp_page;
   logic             move_en;
   cyc_class_e       cls;
   logic             win_wr;

   assign win_wr = cpu_we && (cls == CLS_DATA) && (data_seg == '0);

   seg_ext_regs #(
      .SEG_W(SEG_W), .WIN_BASE(WIN_BASE),
      .DP_ENTRIES(DP_ENTRIES), .DP_IDX_W(DP_IDX_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(win_wr), .addr(cpu_addr),
      .wdata(cpu_wdata), .dp_idx(cs_eff[DP_IDX_W-1:0]),
      .pend_cs(pend_cs), .ds0(ds0), .ds1(ds1), .ss(ss),
      .dp_page(dp_page), .move_en(move_en)
   );

   seg_ext_cs_ctrl #(.SEG_W(SEG_W), .DEPTH(SHADOW_DEPTH)) u_cs (
      .clk(clk), .rst_n(rst_n), .sync(cpu_sync), .vec(cpu_vec),
      .addr(cpu_addr), .rdata(cpu_rdata), .pend_cs(pend_cs),
      .cs_eff(cs_eff), .fault(cs_fault)
   );

   seg_ext_map #(.SEG_W(SEG_W), .LANES(LANES)) u_map (
      .addr(cpu_addr), .we(cpu_we), .sync(cpu_sync), .prog(cpu_prog),
      .vec(cpu_vec), .cs_eff(cs_eff), .ss(ss), .ds0(ds0), .ds1(ds1),
      .move_en(move_en), .dp_page(dp_page), .phys(phys_addr),
      .byte_en(byte_en), .cls(cls), .data_seg(data_seg)
   );

endmodule

// File: rtl/seg_ext_chk.sv
module seg_ext_chk #(
   parameter int PHYS_W = 32,
   parameter int LANES  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [15:0]       cpu_addr,
   input logic              cpu_sync,
   input logic              cpu_prog,
   input logic              cpu_vec,
   input logic [PHYS_W-1:0] phys_addr,
   input logic [LANES-1:0]  byte_en,
   input logic              cs_fault
);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R2: exactly one lane, matching the low address bits
   assert_lane_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(byte_en) == 1) && (((byte_en >> (phys_addr % LANES)) & 1) == 1));

   // R1: offset passes through outside the zero page
   assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:8] != 8'h00) |-> (phys_addr[15:0] == cpu_addr));

   // R4: relocation keeps the byte within the page
   assert_zp_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:8] == 8'h00) |-> (phys_addr[7:0] == cpu_addr[7:0]));

   // R9: reset and IRQ vectors read from segment 0
   assert_boot_vec_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_vec && cpu_addr[15:2] == 14'h3FFF) |-> (phys_addr[PHYS_W-1:16] == '0));

   // R7: operand reads stay in the segment of the cycle before
   assert_operand_seg_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && cpu_prog && !cpu_sync && !cpu_vec && $past(cpu_prog) && !$past(cpu_vec))
      |-> (phys_addr[PHYS_W-1:16] == $past(phys_addr[PHYS_W-1:16])));

   // R11: the underflow flag never clears on its own
   assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(cs_fault)) |-> cs_fault);

endmodule

bind seg_ext_top seg_ext_chk #(.PHYS_W(PHYS_W), .LANES(LANES)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_sync(cpu_sync),
   .cpu_prog(cpu_prog), .cpu_vec(cpu_vec), .phys_addr(phys_addr),
   .byte_en(byte_en), .cs_fault(cs_fault)
);

// File: tb/seg_ext_top_test.sv
module seg_ext_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_rdata = '0;
   logic        cpu_we = 1'b0;
   logic        cpu_sync = 1'b0;
   logic        cpu_prog = 1'b0;
   logic        cpu_vec = 1'b0;
   logic [31:0] phys_addr;
   logic [3:0]  byte_en;
   logic        cs_fault;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   seg_ext_top uut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_we(cpu_we), .cpu_sync(cpu_sync),
      .cpu_prog(cpu_prog), .cpu_vec(cpu_vec), .phys_addr(phys_addr),
      .byte_en(byte_en), .cs_fault(cs_fault)
   );

   task automatic bus(input logic [15:0] a, input logic we, input logic [7:0] wd,
                      input logic [7:0] rd, input logic s, input logic p, input logic v,
                      input logic [31:0] exp, input string req);
      @(negedge clk);
      cpu_addr = a; cpu_we = we; cpu_wdata = wd; cpu_rdata = rd;
      cpu_sync = s; cpu_prog = p; cpu_vec = v;
      #1;
      n_chk++;
      if (phys_addr !== exp) begin
         n_err++;
         $display("FAIL %s: logical %h phys_addr=%h expected %h", req, a, phys_addr, exp);
      end
      n_chk++;
      if (byte_en !== (4'b0001 << exp[1:0])) begin
         n_err++;
         $display("FAIL R2: logical %h byte_en=%b expected %b", a, byte_en, 4'b0001 << exp[1:0]);
      end
   endtask

   task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string req);
      bus(a, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, exp, req);
   endtask
   task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [31:0] exp, input string req);
      bus(a, 1'b1, d, 8'h00, 1'b0, 1'b0, 1'b0, exp, req);
   endtask
   task automatic op(input logic [15:0] a, input logic [7:0] code, input logic [31:0] exp, input string req);
      bus(a, 1'b0, 8'h00, code, 1'b1, 1'b1, 1'b0, exp, req);
   endtask
   task automatic opnd(input logic [15:0] a, input logic [31:0] exp, input string req);
      bus(a, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, exp, req);
   endtask
   task automatic vrd(input logic [15:0] a, input logic [31:0] exp, input string req);
      bus(a, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, exp, req);
   endtask
   task automatic win(input logic [3:0] off, input logic [7:0] d);
      logic [15:0] wa;
      wa = 16'hFF00 | {12'h000, off};
      wr(wa, d, {16'h0000, wa}, "R5");
   endtask

   task automatic chk_fault(input logic exp, input string req);
      @(negedge clk);
      cpu_addr = 16'h4000; cpu_we = 1'b0; cpu_sync = 1'b0; cpu_prog = 1'b0; cpu_vec = 1'b0;
      #1;
      n_chk++;
      if (cs_fault !== exp) begin
         n_err++;
         $display("FAIL %s: cs_fault=%b expected %b", req, cs_fault, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cpu_we = 1'b0; cpu_sync = 1'b0; cpu_prog = 1'b0; cpu_vec = 1'b0;
      cpu_addr = 16'h4000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // R1 R2 R4 R11: state straight after reset
   task automatic t_reset();
      do_reset();
      rd(16'h1234, 32'h0000_1234, "R1");
      rd(16'h1237, 32'h0000_1237, "R1");
      rd(16'h01FF, 32'h0000_01FF, "R1");
      rd(16'h0042, 32'h0000_0042, "R4");
      op(16'h0200, 8'hEA, 32'h0000_0200, "R1");
      chk_fault(1'b0, "R11");
   endtask

   // R3 R4 R5 R6: window loading, zero page, move mode
   task automatic t_regs();
      do_reset();
      win(4'd6, 8'h34);
      rd(16'h01FF, 32'h0000_01FF, "R5");
      win(4'd7, 8'h00);
      rd(16'h01FF, 32'h0034_01FF, "R3");
      win(4'd4, 8'h02);
      win(4'd5, 8'h00);
      win(4'd0, 8'hB1);
      win(4'd1, 8'h0A);
      op(16'h0300, 8'hEA, 32'h0000_0300, "R7");
      win(4'd8, 8'h30);
      rd(16'h0010, 32'h0000_3010, "R4");
      rd(16'h5000, 32'h0000_5000, "R6");
      win(4'd9, 8'h01);
      rd(16'h5004, 32'h0000_5004, "R6");
      wr(16'h5001, 8'hAA, 32'h0002_5001, "R6");
      wr(16'h0011, 8'hAA, 32'h0002_3011, "R4");
      rd(16'h0013, 32'h0000_3013, "R4");
      wr(16'h01FE, 8'hAA, 32'h0034_01FE, "R3");
      opnd(16'h0105, 32'h0000_0105, "R3");
      wr(16'hFF06, 8'h77, 32'h0002_FF06, "R5");
      wr(16'hFF07, 8'h00, 32'h0002_FF07, "R5");
      rd(16'h01FD, 32'h0034_01FD, "R5");
   endtask

   // R4 R7: jumps and per-segment direct page
   task automatic t_jump();
      do_reset();
      win(4'd0, 8'hB1);
      win(4'd1, 8'h0A);
      win(4'd8, 8'h30);
      op(16'h0300, 8'h4C, 32'h0000_0300, "R7");
      opnd(16'h0301, 32'h0000_0301, "R7");
      opnd(16'h0302, 32'h0000_0302, "R7");
      op(16'h1000, 8'hEA, 32'h0AB1_1000, "R7");
      opnd(16'h1001, 32'h0AB1_1001, "R7");
      rd(16'h0010, 32'h0000_0010, "R4");
      win(4'd8, 8'h50);
      rd(16'h0010, 32'h0000_5010, "R4");
      win(4'd0, 8'hB0);
      win(4'd1, 8'h0A);
      op(16'h1002, 8'h6C, 32'h0AB1_1002, "R7");
      opnd(16'h1003, 32'h0AB1_1003, "R7");
      op(16'h2000, 8'hEA, 32'h0AB0_2000, "R7");
      rd(16'h0010, 32'h0000_3010, "R4");
   endtask

   // R10 R11: call, return, underflow
   task automatic t_subr();
      do_reset();
      win(4'd0, 8'h23);
      win(4'd1, 8'h01);
      op(16'h0400, 8'h20, 32'h0000_0400, "R10");
      opnd(16'h0401, 32'h0000_0401, "R10");
      opnd(16'h0402, 32'h0000_0402, "R10");
      wr(16'h01FF, 8'h04, 32'h0000_01FF, "R3");
      wr(16'h01FE, 8'h02, 32'h0000_01FE, "R3");
      op(16'h3000, 8'hEA, 32'h0123_3000, "R10");
      op(16'h3001, 8'h60, 32'h0123_3001, "R10");
      rd(16'h01FE, 32'h0000_01FE, "R3");
      op(16'h0403, 8'hEA, 32'h0000_0403, "R10");
      chk_fault(1'b0, "R11");
      op(16'h0404, 8'h60, 32'h0000_0404, "R11");
      op(16'h0405, 8'hEA, 32'h0000_0405, "R11");
      chk_fault(1'b1, "R11");
      chk_fault(1'b1, "R11");
   endtask

   // R8 R9 R10: NMI, IRQ and reset vectors
   task automatic t_nmi();
      do_reset();
      win(4'd0, 8'h55);
      win(4'd1, 8'h00);
      op(16'h0600, 8'hEA, 32'h0000_0600, "R8");
      vrd(16'hFFFA, 32'h0055_FFFA, "R8");
      vrd(16'hFFFB, 32'h0055_FFFB, "R8");
      op(16'h8000, 8'hEA, 32'h0055_8000, "R8");
      vrd(16'hFFFE, 32'h0000_FFFE, "R9");
      vrd(16'hFFFF, 32'h0000_FFFF, "R9");
      op(16'h9000, 8'hEA, 32'h0055_9000, "R9");
      op(16'h9001, 8'h40, 32'h0055_9001, "R10");
      op(16'h8001, 8'hEA, 32'h0055_8001, "R9");
      op(16'h8002, 8'h40, 32'h0055_8002, "R10");
      op(16'h0601, 8'hEA, 32'h0000_0601, "R8");
      vrd(16'hFFFC, 32'h0000_FFFC, "R9");
      vrd(16'hFFFD, 32'h0000_FFFD, "R9");
      chk_fault(1'b0, "R11");
   endtask

   // R7 R10: software break
   task automatic t_brk();
      do_reset();
      win(4'd0, 8'h77);
      win(4'd1, 8'h07);
      op(16'h0700, 8'h00, 32'h0000_0700, "R7");
      opnd(16'h0701, 32'h0000_0701, "R7");
      vrd(16'hFFFE, 32'h0000_FFFE, "R9");
      vrd(16'hFFFF, 32'h0000_FFFF, "R9");
      op(16'hC000, 8'hEA, 32'h0777_C000, "R7");
      op(16'hC001, 8'h40, 32'h0777_C001, "R10");
      op(16'h0702, 8'hEA, 32'h0000_0702, "R10");
      chk_fault(1'b0, "R10");
   endtask

   // R10 R11: nine nested calls against an 8-entry stack
   task automatic t_depth();
      logic [15:0] cur;
      logic [15:0] nxt;
      do_reset();
      cur = 16'h0000;
      for (int i = 1; i <= 9; i++) begin
         win(4'd0, 8'(i));
         win(4'd1, 8'h00);
         op(16'h0400, 8'h20, {cur, 16'h0400}, "R10");
         op(16'h0500, 8'hEA, {16'(i), 16'h0500}, "R10");
         cur = 16'(i);
      end
      for (int k = 0; k < 9; k++) begin
         op(16'h0600, 8'h60, {cur, 16'h0600}, "R10");
         nxt = (k < 8) ? 16'(8 - k) : cur;
         op(16'h0601, 8'hEA, {nxt, 16'h0601}, "R10");
         cur = nxt;
      end
      chk_fault(1'b1, "R11");
   endtask

   initial begin
      t_reset();
      t_regs();
      t_jump();
      t_subr();
      t_nmi();
      t_brk();
      t_depth();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule